// File: doc/BRIEF.md
# Prescaled Ten-Bit Time-Base Timer

This block measures time in units of the instruction cycle. A qualifying tick, `cyc_tick`, advances a hidden two-bit prescaler. Each time the prescaler passes from its top value back to zero, it bumps a visible eight-bit count by one. The prescaler and the count together behave as a ten-bit time base.

Software can preset the eight-bit count through a load strobe. The same load also forces the prescaler to zero, so a preset interval always starts on a clean quarter boundary. When the count rolls past its top value it raises a sticky wrap flag. Software polls the flag and drops it with a clear strobe. Counting several wraps in software gives intervals longer than 1024 ticks.

A core enable freezes the whole block while it is low, to match a halted core. The block has no streaming data path. Every pin is a plain control or status signal and is sampled on the rising clock edge. The count output can be read at any time and reading it has no side effects.

Top module: `tbt_timebase`

## Requirements
- R1: After reset, `t_count` is 8'h00, `wrap_flag` is 0 and the hidden prescaler is at phase zero.
- R2: With `core_en` high and no load, `t_count` increments by exactly one on the edge that takes the fourth `cyc_tick` since reset or since the last load. It then increments on every fourth tick after that.
- R3: A cycle with `core_en` high and `cyc_tick` low changes neither `t_count` nor the prescaler phase.
- R4: With `core_en` high, `load_en` makes `t_count` equal `load_val` at the next edge and returns the prescaler to phase zero. The following increment therefore needs four fresh ticks.
- R5: If a load and a prescaler carry fall in the same cycle, the load wins. The count takes `load_val` and `wrap_flag` is not set in that cycle, even when the count was 8'hFF.
- R6: A carry while `t_count` is 8'hFF wraps the count to 8'h00 and sets `wrap_flag` at the same edge.
- R7: `wrap_flag` stays set until a cycle with `core_en` and `wrap_clr` both high. The flag then reads 0 after that edge.
- R8: If a wrap and `wrap_clr` happen in the same cycle, the set wins and `wrap_flag` reads 1.
- R9: While `core_en` is low, ticks, loads and clears are ignored. `t_count`, `wrap_flag` and the prescaler phase all hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| core_en | input | 1 | Clock enable; low freezes the block |
| cyc_tick | input | 1 | One instruction-cycle tick per high cycle |
| load_en | input | 1 | Preset strobe for the count |
| load_val | input | 8 | Preset value |
| wrap_clr | input | 1 | Clears the wrap flag |
| t_count | output | 8 | Current count value |
| wrap_flag | output | 1 | Sticky wrap indication |

## Verification
Every result is registered. A load, a clear or a freeze shows at the ports on the first rising edge after the cycle in which it was presented. An increment or a wrap appears at the edge that takes the fourth qualifying tick. The bench drives each cycle's inputs on the falling edge and works out the expected count and flag from its own model of the requirements. It queues that expectation, and a monitor compares it 2 ns after the next rising edge, so each result is checked in exactly the cycle it is due.

// File: rtl/tbt_pkg.sv
package tbt_pkg;
  localparam int unsigned TBT_PRE_W = 2;
  localparam int unsigned TBT_CNT_W = 8;

  typedef struct packed {
    logic load;
    logic adv;
    logic clr;
  } tbt_ctl_t;
endpackage

// File: rtl/tbt_prescaler.sv
module tbt_prescaler #(
  parameter int unsigned PRE_W = tbt_pkg::TBT_PRE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic             restart,
  output logic [PRE_W-1:0] phase,
  output logic             carry
);
  localparam logic [PRE_W-1:0] PRE_TOP = '1;
  localparam logic [PRE_W-1:0] PRE_ONE = PRE_W'(1);

  logic [PRE_W-1:0] phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       phase_q <= '0;
    else if (restart) phase_q <= '0;
    else if (adv)     phase_q <= phase_q + PRE_ONE;
  end

  assign carry = adv && !restart && (phase_q == PRE_TOP);
  assign phase = phase_q;
endmodule

// File: rtl/tbt_counter.sv
module tbt_counter #(
  parameter int unsigned CNT_W = tbt_pkg::TBT_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             step,
  output logic [CNT_W-1:0] count,
  output logic             wrap
);
  localparam logic [CNT_W-1:0] CNT_TOP = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] count_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    count_q <= '0;
    else if (load) count_q <= load_val;
    else if (step) count_q <= count_q + CNT_ONE;
  end

  assign wrap  = step && !load && (count_q == CNT_TOP);
  assign count = count_q;
endmodule

// File: rtl/tbt_flag.sv
module tbt_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag
);
  logic flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flag_q <= 1'b0;
    else if (set) flag_q <= 1'b1;
    else if (clr) flag_q <= 1'b0;
  end

  assign flag = flag_q;
endmodule

// File: rtl/tbt_timebase.sv
module tbt_timebase #(
  parameter int unsigned PRE_W = tbt_pkg::TBT_PRE_W,
  parameter int unsigned CNT_W = tbt_pkg::TBT_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             core_en,
  input  logic             cyc_tick,
  input  logic             load_en,
  input  logic [CNT_W-1:0] load_val,
  input  logic             wrap_clr,
  output logic [CNT_W-1:0] t_count,
  output logic             wrap_flag
);
  tbt_pkg::tbt_ctl_t ctl;
  logic [PRE_W-1:0]  pre_phase;
  logic              pre_carry;
  logic              cnt_wrap;

  // A low core enable masks every qualified action, freezing all state.
  always_comb begin
    ctl.load = core_en & load_en;
    ctl.adv  = core_en & cyc_tick;
    ctl.clr  = core_en & wrap_clr;
  end

  tbt_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .adv     (ctl.adv),
    .restart (ctl.load),
    .phase   (pre_phase),
    .carry   (pre_carry)
  );

  tbt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ctl.load),
    .load_val (load_val),
    .step     (pre_carry),
    .count    (t_count),
    .wrap     (cnt_wrap)
  );

  tbt_flag u_flag (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (cnt_wrap),
    .clr   (ctl.clr),
    .flag  (wrap_flag)
  );
endmodule

// File: rtl/tbt_timebase_chk.sv
module tbt_timebase_chk #(
  parameter int unsigned PRE_W = 2,
  parameter int unsigned CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             core_en,
  input logic             cyc_tick,
  input logic             load_en,
  input logic [CNT_W-1:0] load_val,
  input logic             wrap_clr,
  input logic [CNT_W-1:0] t_count,
  input logic             wrap_flag,
  input logic [PRE_W-1:0] pre_phase
);
  localparam logic [CNT_W-1:0] C_TOP = '1;
  localparam logic [CNT_W-1:0] C_ONE = CNT_W'(1);
  localparam logic [PRE_W-1:0] P_TOP = '1;

  AST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !core_en |=> $stable(t_count) && $stable(wrap_flag) && $stable(pre_phase)); // R9

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    core_en && !load_en && !cyc_tick |=> $stable(t_count) && $stable(pre_phase)); // R3

  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    core_en && load_en |=> (t_count == $past(load_val)) && (pre_phase == '0)); // R4

  AST_LOAD_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    core_en && load_en && !wrap_flag |=> !wrap_flag); // R5

  AST_WRAP_SET: assert property (@(posedge clk) disable iff (!rst_n)
    core_en && cyc_tick && !load_en && pre_phase == P_TOP && t_count == C_TOP
    |=> wrap_flag && t_count == '0); // R6

  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_flag && !(core_en && wrap_clr) |=> wrap_flag); // R7

  AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    core_en && !load_en |=> (t_count == $past(t_count)) ||
                            (t_count == ($past(t_count) + C_ONE))); // R2
endmodule

bind tbt_timebase tbt_timebase_chk #(.PRE_W(PRE_W), .CNT_W(CNT_W)) u_tbt_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .core_en   (core_en),
  .cyc_tick  (cyc_tick),
  .load_en   (load_en),
  .load_val  (load_val),
  .wrap_clr  (wrap_clr),
  .t_count   (t_count),
  .wrap_flag (wrap_flag),
  .pre_phase (pre_phase)
);

// File: tb/tbt_timebase_bench.sv
module tbt_timebase_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       core_en = 1'b0;
  logic       cyc_tick = 1'b0;
  logic       load_en = 1'b0;
  logic [7:0] load_val = 8'h00;
  logic       wrap_clr = 1'b0;
  logic [7:0] t_count;
  logic       wrap_flag;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  typedef struct {
    logic [7:0] cnt;
    logic       flag;
    string      req;
  } exp_t;

  exp_t exp_q[$];

  // independent model of the requirements
  int unsigned m_pre = 0;
  logic [7:0]  m_cnt = 8'h00;
  logic        m_flag = 1'b0;

  always #10 clk = ~clk;

  tbt_timebase u_tbt_timebase (
    .clk(clk), .rst_n(rst_n), .core_en(core_en), .cyc_tick(cyc_tick),
    .load_en(load_en), .load_val(load_val), .wrap_clr(wrap_clr),
    .t_count(t_count), .wrap_flag(wrap_flag)
  );

  task automatic check(input logic [7:0] cnt, input logic flg, input string req);
    checks++;
    if (t_count !== cnt || wrap_flag !== flg) begin
      failures++;
      $display("FAIL %s: count=%h flag=%b expected count=%h flag=%b",
               req, t_count, wrap_flag, cnt, flg);
    end
  endtask

  task automatic step(input logic ce, input logic tk, input logic ld,
                      input logic [7:0] v, input logic clr, input string req);
    exp_t e;
    logic wrapped;
    @(negedge clk);
    core_en = ce; cyc_tick = tk; load_en = ld; load_val = v; wrap_clr = clr;
    wrapped = 1'b0;
    if (ce) begin
      if (ld) begin
        m_cnt = v; m_pre = 0;
      end else if (tk) begin
        if (m_pre == 3) begin
          m_pre = 0;
          if (m_cnt == 8'hFF) wrapped = 1'b1;
          m_cnt = m_cnt + 8'h01;
        end else m_pre = m_pre + 1;
      end
      if (wrapped) m_flag = 1'b1;
      else if (clr) m_flag = 1'b0;
    end
    e.cnt = m_cnt; e.flag = m_flag; e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic ticks(input int n, input string req);
    for (int i = 0; i < n; i++) step(1'b1, 1'b1, 1'b0, 8'h00, 1'b0, req);
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        check(e.cnt, e.flag, e.req);
      end
    end
  end

  initial begin : watchdog
    #2000000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    check(8'h00, 1'b0, "R1 reset state");
    rst_n = 1'b1;
    // R1/R2: first increment exactly on the fourth tick after reset
    ticks(8, "R2 divide by four");
    // R3: idle cycles hold count and phase
    ticks(2, "R2 partial phase");
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0, 1'b0, 8'h00, 1'b0, "R3 no tick");
    ticks(2, "R3 phase kept");
    // R4: load mid-phase restarts prescaler
    ticks(2, "R4 pre-load ticks");
    step(1'b1, 1'b0, 1'b1, 8'h10, 1'b0, "R4 load");
    ticks(5, "R4 four fresh ticks");
    // R6: wrap from FF sets flag
    step(1'b1, 1'b0, 1'b1, 8'hFD, 1'b0, "R4 preset");
    ticks(12, "R6 wrap");
    // R7: sticky, then clear
    ticks(6, "R7 flag held");
    step(1'b1, 1'b0, 1'b0, 8'h00, 1'b1, "R7 clear");
    ticks(2, "R7 stays clear");
    // R5: load coincides with carry at FF
    step(1'b1, 1'b0, 1'b1, 8'hFF, 1'b0, "R5 preset FF");
    ticks(3, "R5 to top phase");
    step(1'b1, 1'b1, 1'b1, 8'h55, 1'b0, "R5 load beats carry");
    ticks(4, "R5 restart after load");
    // R8: wrap and clear together
    step(1'b1, 1'b0, 1'b1, 8'hFF, 1'b0, "R8 preset FF");
    ticks(3, "R8 to top phase");
    step(1'b1, 1'b1, 1'b0, 8'h00, 1'b1, "R8 set wins");
    // R9: frozen while core_en low
    ticks(2, "R9 mid phase");
    step(1'b0, 1'b1, 1'b0, 8'h00, 1'b0, "R9 frozen tick");
    step(1'b0, 1'b1, 1'b1, 8'hAA, 1'b0, "R9 frozen load");
    step(1'b0, 1'b0, 1'b0, 8'h00, 1'b1, "R9 frozen clear");
    step(1'b0, 1'b1, 1'b0, 8'h00, 1'b1, "R9 frozen both");
    ticks(2, "R9 resume phase");
    step(1'b1, 1'b0, 1'b0, 8'h00, 1'b0, "R9 idle");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule